// File: doc/BRIEF.md
# Dual-Wiper Serial Loader with Cascade Output

This block is the digital front end of a dual 256-step digital potentiometer. A three-wire serial port carries a load-enable level, a serial clock and a data line. While the enable is high, each rising edge of the serial clock moves one data bit into a 17-bit shift register. The bit that falls off the far end of that register is presented on a cascade pin, so further loaders can be chained behind it. When the enable drops, the register contents are copied into the two wiper code registers and the stack-select register. Those registers feed the resistor ladders and the shared stacked-output multiplexer, which sit outside this block.

A frame is sent in this order: the stack-select bit, then the wiper-1 code, then the wiper-0 code. Each code goes most-significant bit first. For a chain of N loaders, the host sends 17×N bits inside one enable window, starting with the frame meant for the device furthest along the chain.

All serial pins are sampled on the system clock. A serial-clock edge is detected as a low sample followed by a high sample. The enable falling edge is detected as a high sample followed by a low sample.

Top module: `dpot_serial_loader`

## Requirements
- R1: After a synchronous reset, both wiper codes read 0x80 and stack_sel reads 0. The shift register is cleared, so cascade_out reads 0.
- R2: After exactly 17 shifts and a fall of ser_en, the outputs hold the frame. stack_sel takes the first bit. wiper1_code takes bits 2 to 9, with bit 2 as its MSB. wiper0_code takes bits 10 to 17, with bit 10 as its MSB.
- R3: The wiper codes and stack_sel change only on the cycle that follows a high-to-low transition of ser_en. They stay unchanged while bits are being shifted.
- R4: While ser_en is low, serial-clock edges and data are ignored. cascade_out stays unchanged. A later enable pulse with no shifts re-applies the earlier register contents unchanged.
- R5: cascade_out always shows the oldest bit held in the register, which is the next bit to be shifted out. Once more than 17 bits have been shifted, it shows the bit sent 17 positions earlier.
- R6: When 34 bits are sent in one window, the first 17 bits come out on cascade_out and the last 17 bits are applied.
- R7: A window of fewer than 17 bits leaves the register misaligned. The applied frame is the last 17 bits the register has received, counted across windows.
- R8: Codes 0x00 and 0xFF pass through unchanged. stack_sel = 1 selects wiper 1 and stack_sel = 0 selects wiper 0 for the stacked output.
- R9: A serial clock held high for several system cycles shifts only once. Raising ser_en while ser_clk is already high does not shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Load enable; high opens a shift window, falling edge applies |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_din | input | 1 | Serial data in |
| cascade_out | output | 1 | Oldest register bit, for the next loader's ser_din |
| wiper0_code | output | 8 | Applied wiper-0 code (0x00 low end, 0xFF high end) |
| wiper1_code | output | 8 | Applied wiper-1 code |
| stack_sel | output | 1 | Stacked-output select: 0 picks wiper 0, 1 picks wiper 1 |

## Verification
The assertions assume that every serial pin changes synchronously to clk. They also assume each level of ser_clk and ser_en is held for at least one sample, so edge detection never misses a transition. They further assume ser_en is low on the cycle that reset is released. The stimulus meets these conditions by driving on the falling edge of clk and holding each serial-clock phase for two cycles. It also keeps ser_en low throughout reset and changes ser_en only in cycles where no shift edge is pending.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic {
    STK_WIPER0 = 1'b0,
    STK_WIPER1 = 1'b1
  } stk_sel_e;

  function automatic int frame_bits(input int code_w);
    return 2 * code_w + 1;
  endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic ser_en,
  input  logic ser_clk,
  output logic shift_stb,
  output logic apply_stb
);
  logic clk_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      clk_q <= ser_clk;
      en_q  <= ser_en;
    end
  end

  assign shift_stb = ser_en & ser_clk & ~clk_q;
  assign apply_stb = en_q & ~ser_en;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_stb,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               casc
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (shift_stb) sr <= {din, sr[FRAME_W-1:1]};
  end

  assign frame = sr;
  assign casc  = sr[0];
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import dpot_pkg::*;
#(
  parameter int CODE_W  = 8,
  localparam int FRAME_W = 2 * CODE_W + 1,
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apply_stb,
  input  logic [FRAME_W-1:0] frame,
  output logic [CODE_W-1:0]  w0,
  output logic [CODE_W-1:0]  w1,
  output stk_sel_e           sel
);
  logic [CODE_W-1:0] w0_next;
  logic [CODE_W-1:0] w1_next;

  for (genvar j = 0; j < CODE_W; j++) begin : g_unpack
    assign w1_next[j] = frame[CODE_W - j];
    assign w0_next[j] = frame[2 * CODE_W - j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w0  <= MID_CODE;
      w1  <= MID_CODE;
      sel <= STK_WIPER0;
    end else if (apply_stb) begin
      w0  <= w0_next;
      w1  <= w1_next;
      sel <= stk_sel_e'(frame[0]);
    end
  end
endmodule

// File: rtl/dpot_serial_loader.sv
module dpot_serial_loader
  import dpot_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              cascade_out,
  output logic [CODE_W-1:0] wiper0_code,
  output logic [CODE_W-1:0] wiper1_code,
  output logic              stack_sel
);
  localparam int FRAME_W = frame_bits(CODE_W);

  logic               shift_stb;
  logic               apply_stb;
  logic [FRAME_W-1:0] frame;
  stk_sel_e           sel_q;

  ser_edge_sync i_edge (
    .clk       (clk),
    .rst       (rst),
    .ser_en    (ser_en),
    .ser_clk   (ser_clk),
    .shift_stb (shift_stb),
    .apply_stb (apply_stb)
  );

  frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_stb (shift_stb),
    .din       (ser_din),
    .frame     (frame),
    .casc      (cascade_out)
  );

  wiper_bank #(.CODE_W(CODE_W)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .apply_stb (apply_stb),
    .frame     (frame),
    .w0        (wiper0_code),
    .w1        (wiper1_code),
    .sel       (sel_q)
  );

  assign stack_sel = sel_q;
endmodule

// File: rtl/dpot_serial_loader_chk.sv
module dpot_serial_loader_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_en,
  input logic              cascade_out,
  input logic [CODE_W-1:0] wiper0_code,
  input logic [CODE_W-1:0] wiper1_code,
  input logic              stack_sel
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper0_code == MID && wiper1_code == MID && !stack_sel && !cascade_out)); // R1

  AST_W0_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper0_code) |-> ($past(ser_en, 2) && !$past(ser_en))); // R3

  AST_W1_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper1_code) |-> ($past(ser_en, 2) && !$past(ser_en))); // R3

  AST_SEL_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(stack_sel) |-> ($past(ser_en, 2) && !$past(ser_en))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ser_en) |-> $stable(cascade_out)); // R4
endmodule

bind dpot_serial_loader dpot_serial_loader_chk #(.CODE_W(CODE_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .ser_en      (ser_en),
  .cascade_out (cascade_out),
  .wiper0_code (wiper0_code),
  .wiper1_code (wiper1_code),
  .stack_sel   (stack_sel)
);

// File: tb/test_dpot_serial_loader.sv
module test_dpot_serial_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic       cascade_out;
  logic [7:0] wiper0_code;
  logic [7:0] wiper1_code;
  logic       stack_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // window model: win[0] is the oldest of the last 17 bits received
  logic win [17];
  logic [16:0] app_sel;
  logic [7:0] exp_w0, exp_w1;
  logic exp_sel;

  // each entry: {sel, wiper1, wiper0}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h12, 8'h34}, {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h00, 8'hFF},
    {1'b1, 8'hA5, 8'h5A}, {1'b0, 8'h01, 8'h80}, {1'b1, 8'h7E, 8'h81},
    {1'b0, 8'hFF, 8'hFF}, {1'b1, 8'h00, 8'h00}
  };

  dpot_serial_loader i_dpot_serial_loader (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .cascade_out(cascade_out), .wiper0_code(wiper0_code),
    .wiper1_code(wiper1_code), .stack_sel(stack_sel)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 17; i++) win[i] = 1'b0;
  endtask

  task automatic model_apply();
    exp_sel = win[0];
    for (int i = 0; i < 8; i++) begin
      exp_w1[7 - i] = win[1 + i];
      exp_w0[7 - i] = win[9 + i];
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b1;
    @(negedge clk);
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) win[i] = win[i + 1];
    win[16] = b;
  endtask

  task automatic open_win();
    @(negedge clk); ser_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk); ser_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_apply();
  endtask

  task automatic send_frame(input logic [16:0] v);
    send_bit(v[16]);
    for (int i = 15; i >= 8; i--) send_bit(v[i]);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic check_out(input string req);
    chk({req, " wiper0"}, 32'(wiper0_code), 32'(exp_w0));
    chk({req, " wiper1"}, 32'(wiper1_code), 32'(exp_w1));
    chk({req, " sel"}, 32'(stack_sel), 32'(exp_sel));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wiper0", 32'(wiper0_code), 32'h80);
    chk("R1 wiper1", 32'(wiper1_code), 32'h80);
    chk("R1 sel", 32'(stack_sel), 32'h0);
    chk("R1 cascade", 32'(cascade_out), 32'h0);

    // R2/R8 table walk
    foreach (VEC[k]) begin
      open_win();
      send_frame(VEC[k]);
      close_win();
      chk("R2 sel", 32'(stack_sel), 32'(VEC[k][16]));
      chk("R2 wiper1", 32'(wiper1_code), 32'(VEC[k][15:8]));
      chk("R8 wiper0", 32'(wiper0_code), 32'(VEC[k][7:0]));
    end

    // R3: outputs hold mid-frame
    open_win();
    send_frame({1'b1, 8'h3C, 8'hC3});
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    chk("R3 wiper0 held", 32'(wiper0_code), 32'h00);
    chk("R3 wiper1 held", 32'(wiper1_code), 32'h00);
    chk("R3 sel held", 32'(stack_sel), 32'h1);
    // R7: partial content: 20 bits total, last 17 applied
    close_win();
    check_out("R7 misaligned");

    // R4: idle clocks ignored
    begin
      logic c0;
      c0 = cascade_out;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); ser_din = i[0]; ser_clk = 1'b1;
        @(negedge clk); ser_clk = 1'b0;
        chk("R4 cascade idle", 32'(cascade_out), 32'(c0));
      end
    end
    open_win();
    close_win();
    check_out("R4 reapply");

    // R5/R6: two frames in one window
    begin
      logic [16:0] fa, fb;
      fa = {1'b1, 8'hC8, 8'h13};
      fb = {1'b0, 8'h6E, 8'h9B};
      open_win();
      send_frame(fa);
      for (int i = 16; i >= 0; i--) begin
        chk("R5 cascade pending", 32'(cascade_out), 32'(win[0]));
        chk("R6 cascade frame A", 32'(cascade_out), 32'(fa[i]));
        send_bit(fb[i]);
      end
      close_win();
      chk("R6 sel", 32'(stack_sel), 32'(fb[16]));
      chk("R6 wiper1", 32'(wiper1_code), 32'(fb[15:8]));
      chk("R6 wiper0", 32'(wiper0_code), 32'(fb[7:0]));
    end

    // R9: long high clock shifts once; enable rising with clock high no shift
    open_win();
    send_frame(17'h0);
    @(negedge clk); ser_din = 1'b1; ser_clk = 1'b1;
    repeat (10) @(negedge clk);
    ser_clk = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) win[i] = win[i + 1];
    win[16] = 1'b1;
    close_win();
    check_out("R9 single shift");
    @(negedge clk); ser_clk = 1'b1; ser_din = 1'b1;
    @(negedge clk); ser_en = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    @(negedge clk);
    close_win();
    check_out("R9 no shift on enable");

    // R1: mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rerun wiper0", 32'(wiper0_code), 32'h80);
    chk("R1 rerun wiper1", 32'(wiper1_code), 32'h80);
    chk("R1 rerun cascade", 32'(cascade_out), 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule